// File: doc/BRIEF.md
# Buffered Crossbar Cell Scheduler (Empty-Column-First Input, Flagged-Removal Output)

This block schedules a square buffered crossbar. Every crosspoint (input i, output j) holds a buffer of one cell. Each input keeps one virtual output queue per output. The scheduler models only the occupancy of those buffers; cell payloads and line interfaces live elsewhere. One clock cycle is one time slot. In each slot the scheduler does three things. Each input moves at most one cell from a virtual output queue into its crosspoint buffer. Each output drains at most one occupied crosspoint in its column. The buffers that were drained are reported back to the inputs.

The input side favours output columns whose crosspoint buffers are all empty, so that idle outputs get work first. When no such column is eligible, it falls back to round-robin. Each input can also flag one of its already-buffered cells as waiting, through a single remove-request. Each output serves flagged cells ahead of the rest of its column, and uses plain round-robin when nothing is flagged. All decisions for a slot are formed from the occupancy at the start of that slot. They appear on registered outputs after the slot's clock edge.

Crosspoint (input i, output j) uses flat bit index i*N + j in every N*N-wide vector. Selection fields are PW = clog2(N) bits wide, packed per input or per output at offset k*PW.

Top module: `bx_ecf_remove_sched`

## Requirements
- R1: While reset is high, every registered output is zero: no grants, no remove-requests, no departures, no releases, and an empty occupancy map. All round-robin pointers restart at 0.
- R2: An input may select output j only when queue (i,j) is non-empty and crosspoint (i,j) was unoccupied at the start of the slot. With no such queue, in_vld[i] is 0.
- R3: If any eligible output of input i has a column that is entirely unoccupied, the input selects the first such output, scanning from its pointer upward with wrap-around.
- R4: Otherwise the input selects the first eligible output, scanning from its pointer upward with wrap-around.
- R5: After a selection the input's pointer becomes the selected output plus one, modulo N. Without a selection the pointer is unchanged.
- R6: Each input raises at most one remove-request per slot. It names the first output j, scanning from the input's pointer at the start of the slot, whose queue (i,j) is non-empty while crosspoint (i,j) is occupied. There is no request when no such output exists.
- R7: An output that receives one or more remove-requests departs the first requesting input, scanning from the output's pointer upward with wrap-around.
- R8: An output with no remove-request departs the first input whose crosspoint in its column is occupied, using the same scan. An output whose column is empty departs nothing.
- R9: After a departure the output's pointer becomes the departed input plus one, modulo N. Without a departure the pointer is unchanged.
- R10: The occupancy map after a slot equals the previous map, minus the departed crosspoints, plus the crosspoints granted to inputs. A cell written in a slot cannot depart in that same slot.
- R11: release_o has bit i*N+j set exactly when output j departed input i in the slot just ended. There is at most one bit per output column.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock |
| rst | input | 1 | Synchronous active-high reset |
| voq_nonempty | input | N*N | Bit i*N+j: input i holds a cell for output j |
| in_vld | output | N | Input i granted a crosspoint write this slot |
| in_sel | output | N*PW | Output chosen by each input |
| rmv_vld | output | N | Input i raised a remove-request |
| rmv_out | output | N*PW | Output addressed by each remove-request |
| out_vld | output | N | Output j departed a cell |
| out_src | output | N*PW | Input whose crosspoint output j drained |
| release_o | output | N*N | Freed crosspoints, notified back to inputs |
| occ_o | output | N*N | Crosspoint occupancy after the slot |

## Verification
The 4x4 configuration is first driven with all queues idle, all queues full, and a single queue held busy. All-full separates the empty-column path from the round-robin fallback: once the columns fill up, only the round-robin fallback can pick. A single busy queue shows a write, then a flagged removal, then a fresh write in consecutive slots. After that, every one of the 65536 request patterns is applied once, in a scrambled order, on top of the occupancy that has built up. This mixes slots where some columns are empty with slots where none are, and slots with and without flagged cells. It tells apart errors in pointer advance, in the priority of flagged cells over plain round-robin, and in the timing of occupancy updates. A reset in the middle of the run confirms that state and pointers clear.

// File: rtl/bx_pkg.sv
package bx_pkg;
  // Next position of a circular pointer over n slots.
  function automatic int wrap_next(input int cur, input int n);
    return (cur >= n - 1) ? 0 : cur + 1;
  endfunction
endpackage

// File: rtl/bx_rr_pick.sv
// First set request at or after ptr, with wrap-around.
module bx_rr_pick #(
  parameter int N = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [PW-1:0] ptr,
  output logic          hit,
  output logic [PW-1:0] idx
);
  int p;
  always_comb begin
    hit = 1'b0;
    idx = '0;
    p   = 0;
    for (int k = 0; k < N; k++) begin
      p = (int'(ptr) + k) % N;
      if (!hit && req[p]) begin
        hit = 1'b1;
        idx = PW'(p);
      end
    end
  end
endmodule

// File: rtl/bx_in_sched.sv
// Per-input decision: empty-column pick, round-robin fallback, remove-request.
module bx_in_sched #(
  parameter int N = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  voq_row,
  input  logic [N-1:0]  occ_row,
  input  logic [N-1:0]  col_empty,
  input  logic [PW-1:0] ptr,
  output logic          gnt,
  output logic [PW-1:0] gnt_idx,
  output logic          rmv,
  output logic [PW-1:0] rmv_idx
);
  logic [N-1:0]  elig;
  logic [N-1:0]  elig_empty;
  logic [N-1:0]  blocked;
  logic          ec_hit, rr_hit;
  logic [PW-1:0] ec_idx, rr_idx;

  assign elig       = voq_row & ~occ_row;
  assign elig_empty = elig & col_empty;
  assign blocked    = voq_row & occ_row;

  bx_rr_pick #(.N(N)) u_pick_empty (.req(elig_empty), .ptr(ptr), .hit(ec_hit), .idx(ec_idx));
  bx_rr_pick #(.N(N)) u_pick_rr    (.req(elig),       .ptr(ptr), .hit(rr_hit), .idx(rr_idx));
  bx_rr_pick #(.N(N)) u_pick_rmv   (.req(blocked),    .ptr(ptr), .hit(rmv),    .idx(rmv_idx));

  // any-grant from the empty-column picker steers the result
  assign gnt     = ec_hit | rr_hit;
  assign gnt_idx = ec_hit ? ec_idx : rr_idx;
endmodule

// File: rtl/bx_out_sched.sv
// Per-output decision: flagged crosspoints first, else plain round-robin.
module bx_out_sched #(
  parameter int N = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_col,
  input  logic [N-1:0]  occ_col,
  input  logic [PW-1:0] ptr,
  output logic          hit,
  output logic [PW-1:0] idx
);
  logic          rq_hit, oc_hit;
  logic [PW-1:0] rq_idx, oc_idx;

  bx_rr_pick #(.N(N)) u_pick_req (.req(req_col), .ptr(ptr), .hit(rq_hit), .idx(rq_idx));
  bx_rr_pick #(.N(N)) u_pick_occ (.req(occ_col), .ptr(ptr), .hit(oc_hit), .idx(oc_idx));

  assign hit = rq_hit | oc_hit;
  assign idx = rq_hit ? rq_idx : oc_idx;
endmodule

// File: rtl/bx_ecf_remove_sched.sv
module bx_ecf_remove_sched #(
  parameter int N = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1,
  localparam int NN = N * N
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NN-1:0]   voq_nonempty,
  output logic [N-1:0]    in_vld,
  output logic [N*PW-1:0] in_sel,
  output logic [N-1:0]    rmv_vld,
  output logic [N*PW-1:0] rmv_out,
  output logic [N-1:0]    out_vld,
  output logic [N*PW-1:0] out_src,
  output logic [NN-1:0]   release_o,
  output logic [NN-1:0]   occ_o
);
  import bx_pkg::*;

  logic [PW-1:0] in_ptr_q  [N];
  logic [PW-1:0] out_ptr_q [N];
  logic [N-1:0]  col_empty;
  logic [N-1:0]  g_hit, r_hit, d_hit;
  logic [PW-1:0] g_idx [N];
  logic [PW-1:0] r_idx [N];
  logic [PW-1:0] d_idx [N];
  logic [NN-1:0] wr_vec, dep_vec;

  // column occupancy summary
  for (genvar j = 0; j < N; j++) begin : g_col
    logic [N-1:0] col_bits;
    for (genvar i = 0; i < N; i++) begin : g_bit
      assign col_bits[i] = occ_o[i*N + j];
    end
    assign col_empty[j] = ~|col_bits;
  end

  // input stage
  for (genvar i = 0; i < N; i++) begin : g_in
    bx_in_sched #(.N(N)) u_in (
      .voq_row  (voq_nonempty[i*N +: N]),
      .occ_row  (occ_o[i*N +: N]),
      .col_empty(col_empty),
      .ptr      (in_ptr_q[i]),
      .gnt      (g_hit[i]),
      .gnt_idx  (g_idx[i]),
      .rmv      (r_hit[i]),
      .rmv_idx  (r_idx[i])
    );
  end

  // output stage
  for (genvar j = 0; j < N; j++) begin : g_out
    logic [N-1:0] req_col, occ_col;
    for (genvar i = 0; i < N; i++) begin : g_src
      assign req_col[i] = r_hit[i] && (int'(r_idx[i]) == j);
      assign occ_col[i] = occ_o[i*N + j];
    end
    bx_out_sched #(.N(N)) u_out (
      .req_col(req_col),
      .occ_col(occ_col),
      .ptr    (out_ptr_q[j]),
      .hit    (d_hit[j]),
      .idx    (d_idx[j])
    );
  end

  // crosspoint write and departure vectors
  always_comb begin
    wr_vec  = '0;
    dep_vec = '0;
    for (int i = 0; i < N; i++)
      if (g_hit[i]) wr_vec[i*N + int'(g_idx[i])] = 1'b1;
    for (int j = 0; j < N; j++)
      if (d_hit[j]) dep_vec[int'(d_idx[j])*N + j] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_o     <= '0;
      release_o <= '0;
      in_vld    <= '0;
      in_sel    <= '0;
      rmv_vld   <= '0;
      rmv_out   <= '0;
      out_vld   <= '0;
      out_src   <= '0;
      for (int k = 0; k < N; k++) begin
        in_ptr_q[k]  <= '0;
        out_ptr_q[k] <= '0;
      end
    end else begin
      occ_o     <= (occ_o & ~dep_vec) | wr_vec;
      release_o <= dep_vec;
      in_vld    <= g_hit;
      rmv_vld   <= r_hit;
      out_vld   <= d_hit;
      for (int k = 0; k < N; k++) begin
        in_sel[k*PW +: PW]  <= g_idx[k];
        rmv_out[k*PW +: PW] <= r_idx[k];
        out_src[k*PW +: PW] <= d_idx[k];
        if (g_hit[k]) in_ptr_q[k]  <= PW'(wrap_next(int'(g_idx[k]), N));
        if (d_hit[k]) out_ptr_q[k] <= PW'(wrap_next(int'(d_idx[k]), N));
      end
    end
  end
endmodule

// File: rtl/bx_ecf_remove_chk.sv
module bx_ecf_remove_chk #(
  parameter int N = 4,
  localparam int PW = (N > 1) ? $clog2(N) : 1,
  localparam int NN = N * N
) (
  input logic            clk,
  input logic            rst,
  input logic [NN-1:0]   voq_nonempty,
  input logic [N-1:0]    in_vld,
  input logic [N*PW-1:0] in_sel,
  input logic [N-1:0]    rmv_vld,
  input logic [N*PW-1:0] rmv_out,
  input logic [N-1:0]    out_vld,
  input logic [N*PW-1:0] out_src,
  input logic [NN-1:0]   release_o,
  input logic [NN-1:0]   occ_o
);
  logic [1:0]    age;
  logic          rst_d;
  logic          live;
  logic [NN-1:0] gnt_vec, rq_vec;
  logic [N-1:0]  occ_any, rq_any, srv_rq;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) age <= 2'd0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  assign live = (age != 2'd0);

  always_comb begin
    gnt_vec = '0;
    rq_vec  = '0;
    occ_any = '0;
    rq_any  = '0;
    srv_rq  = '0;
    for (int i = 0; i < N; i++) begin
      if (in_vld[i])  gnt_vec[i*N + int'(in_sel[i*PW +: PW])]  = 1'b1;
      if (rmv_vld[i]) rq_vec[i*N + int'(rmv_out[i*PW +: PW])] = 1'b1;
    end
    for (int j = 0; j < N; j++) begin
      for (int i = 0; i < N; i++) begin
        occ_any[j] = occ_any[j] | occ_o[i*N + j];
        rq_any[j]  = rq_any[j]  | rq_vec[i*N + j];
      end
      srv_rq[j] = rq_vec[int'(out_src[j*PW +: PW])*N + j];
    end
  end

  // R1
  always_ff @(posedge clk) begin
    if (rst_d) begin
      reset_clear_chk: assert (occ_o == '0 && release_o == '0 && in_vld == '0 &&
                               rmv_vld == '0 && out_vld == '0);
    end
  end

  // R2
  gnt_free_chk: assert property (@(posedge clk) disable iff (rst || !live)
    (gnt_vec & $past(occ_o)) == '0);

  // R10
  occ_track_chk: assert property (@(posedge clk) disable iff (rst || !live)
    occ_o == (($past(occ_o) & ~release_o) | gnt_vec));

  // R11
  release_occ_chk: assert property (@(posedge clk) disable iff (rst || !live)
    (release_o & ~$past(occ_o)) == '0);

  // R6
  rmv_occ_chk: assert property (@(posedge clk) disable iff (rst || !live)
    (rq_vec & ~$past(occ_o)) == '0);

  for (genvar j = 0; j < N; j++) begin : g_chk
    logic [N-1:0] rel_col;
    for (genvar i = 0; i < N; i++) begin : g_b
      assign rel_col[i] = release_o[i*N + j];
    end
    // R7
    flag_first_chk: assert property (@(posedge clk) disable iff (rst || !live)
      rq_any[j] |-> (out_vld[j] && srv_rq[j]));
    // R8
    work_cons_chk: assert property (@(posedge clk) disable iff (rst || !live)
      out_vld[j] == $past(occ_any[j]));
    // R11
    rel_one_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0(rel_col) && (out_vld[j] == (|rel_col)));
  end
endmodule

bind bx_ecf_remove_sched bx_ecf_remove_chk #(.N(N)) u_chk (.*);

// File: tb/bx_ecf_remove_sched_tb.sv
`timescale 1ns/1ps
module bx_ecf_remove_sched_tb;
  localparam int N  = 4;
  localparam int PW = 2;
  localparam int NN = N * N;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NN-1:0]   voq = '0;
  logic [N-1:0]    in_vld, rmv_vld, out_vld;
  logic [N*PW-1:0] in_sel, rmv_out, out_src;
  logic [NN-1:0]   release_o, occ_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  bit m_occ [NN];
  int m_ip  [N];
  int m_op  [N];

  always #10 clk = ~clk;

  bx_ecf_remove_sched #(.N(N)) u_dut (
    .clk(clk), .rst(rst), .voq_nonempty(voq),
    .in_vld(in_vld), .in_sel(in_sel), .rmv_vld(rmv_vld), .rmv_out(rmv_out),
    .out_vld(out_vld), .out_src(out_src), .release_o(release_o), .occ_o(occ_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int k = 0; k < NN; k++) m_occ[k] = 1'b0;
    for (int k = 0; k < N; k++) begin m_ip[k] = 0; m_op[k] = 0; end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    voq = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: everything cleared while reset holds
    chk(occ_o == '0, "R1 occ", int'(occ_o), 0);
    chk(release_o == '0, "R1 release", int'(release_o), 0);
    chk(in_vld == '0 && rmv_vld == '0 && out_vld == '0, "R1 valids",
        int'({in_vld, rmv_vld, out_vld}), 0);
    rst = 1'b0;
    model_clear();
  endtask

  // Apply one slot, predict from the requirements, compare after the edge.
  task automatic step(input logic [NN-1:0] v);
    int e_iv [N]; int e_is [N]; int e_rv [N]; int e_ro [N];
    int e_ov [N]; int e_os [N]; bit e_emp [N];
    bit colz [N];
    bit n_occ [NN];
    bit grant_prev [N];
    int j, i, act_i;
    string tg;
    for (int c = 0; c < N; c++) begin
      colz[c] = 1'b1;
      for (int r = 0; r < N; r++) if (m_occ[r*N+c]) colz[c] = 1'b0;
    end
    for (int r = 0; r < N; r++) begin
      e_iv[r] = 0; e_is[r] = 0; e_rv[r] = 0; e_ro[r] = 0; e_emp[r] = 1'b0;
      for (int k = 0; k < N; k++) begin
        j = (m_ip[r] + k) % N;
        if (e_iv[r] == 0 && v[r*N+j] && !m_occ[r*N+j] && colz[j]) begin
          e_iv[r] = 1; e_is[r] = j; e_emp[r] = 1'b1;
        end
      end
      for (int k = 0; k < N; k++) begin
        j = (m_ip[r] + k) % N;
        if (e_iv[r] == 0 && v[r*N+j] && !m_occ[r*N+j]) begin
          e_iv[r] = 1; e_is[r] = j;
        end
        if (e_rv[r] == 0 && v[r*N+j] && m_occ[r*N+j]) begin
          e_rv[r] = 1; e_ro[r] = j;
        end
      end
    end
    for (int c = 0; c < N; c++) begin
      e_ov[c] = 0; e_os[c] = 0;
      for (int k = 0; k < N; k++) begin
        i = (m_op[c] + k) % N;
        if (e_ov[c] == 0 && e_rv[i] == 1 && e_ro[i] == c) begin e_ov[c] = 1; e_os[c] = i; end
      end
      for (int k = 0; k < N; k++) begin
        i = (m_op[c] + k) % N;
        if (e_ov[c] == 0 && m_occ[i*N+c]) begin e_ov[c] = 1; e_os[c] = i; end
      end
    end
    for (int k = 0; k < NN; k++) n_occ[k] = m_occ[k];
    for (int c = 0; c < N; c++) if (e_ov[c] == 1) n_occ[e_os[c]*N+c] = 1'b0;
    for (int r = 0; r < N; r++) begin
      grant_prev[r] = (e_iv[r] == 1);
      if (e_iv[r] == 1) n_occ[r*N+e_is[r]] = 1'b1;
    end

    voq = v;
    @(posedge clk);
    @(negedge clk);

    for (int r = 0; r < N; r++) begin
      tg = (e_iv[r] == 0) ? "R2 grant" : (e_emp[r] ? "R3,R5 empty-column pick" : "R4,R5 round-robin pick");
      chk(int'(in_vld[r]) == e_iv[r], tg, int'(in_vld[r]), e_iv[r]);
      if (e_iv[r] == 1) begin
        act_i = int'(in_sel[r*PW +: PW]);
        chk(act_i == e_is[r], tg, act_i, e_is[r]);
      end
      // R6
      chk(int'(rmv_vld[r]) == e_rv[r], "R6 request valid", int'(rmv_vld[r]), e_rv[r]);
      if (e_rv[r] == 1) begin
        act_i = int'(rmv_out[r*PW +: PW]);
        chk(act_i == e_ro[r], "R6 request target", act_i, e_ro[r]);
      end
    end
    for (int c = 0; c < N; c++) begin
      tg = "R8,R9 output round-robin";
      for (int r = 0; r < N; r++) if (e_rv[r] == 1 && e_ro[r] == c) tg = "R7,R9 flagged removal";
      chk(int'(out_vld[c]) == e_ov[c], tg, int'(out_vld[c]), e_ov[c]);
      if (e_ov[c] == 1) begin
        act_i = int'(out_src[c*PW +: PW]);
        chk(act_i == e_os[c], tg, act_i, e_os[c]);
      end
    end
    for (int k = 0; k < NN; k++) begin
      bit rel_e;
      rel_e = (e_ov[k%N] == 1) && (e_os[k%N] == k/N);
      chk(release_o[k] == rel_e, "R11 release", int'(release_o[k]), int'(rel_e));
      chk(occ_o[k] == n_occ[k], "R10 occupancy", int'(occ_o[k]), int'(n_occ[k]));
      m_occ[k] = n_occ[k];
    end
    for (int r = 0; r < N; r++) begin
      if (grant_prev[r]) m_ip[r] = (e_is[r] + 1) % N;
      if (e_ov[r] == 1)  m_op[r] = (e_os[r] + 1) % N;
    end
  endtask

  initial begin
    model_clear();
    do_reset();
    repeat (3) step('0);
    repeat (12) step('1);
    repeat (3) step('0);
    repeat (5) step(16'h0004);
    repeat (3) step(16'h8421);
    for (int p = 0; p < 65536; p++) begin
      int s;
      s = (p * 40503) & 16'hFFFF;
      step(s[15:0]);
      if (p == 30000) do_reset();
    end
    repeat (4) step('0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule